// File: doc/BRIEF.md
# L1 Transactional Metadata Conflict Checker

This block holds a very small amount of transactional metadata for every line of a private cache and detects conflicts between transactions. Per line it keeps one access bit per hardware context, set when that context touches the line inside a transaction, and one shared bit saying that transactional state for the line has migrated to another cache. The line's write status is not stored. It is inferred from the Modified coherence state, which the coherence controller supplies with each access or snoop.

Local loads and stores are checked against the bits of the line they target. A local access that hits a migrated-state line, or that clashes with another context's bit, is reported as a fault and leaves the bits unchanged. Software then walks the transaction logs and retries the access. Incoming snoops are checked the same way. A snoop always proceeds and is never held back. A clash is reported on a separate channel, and a transfer indication is returned at once so that the requester can mark its own copy.

Commit or abort of a context clears that context's bits everywhere in one cycle. A fill that arrives with a transfer indication sets the migrated-state bit. Software clears that bit again through a dedicated clear port once its log walk is done.

Top module: `tmeta_conflict_chk`

## Requirements
- R1: After reset no line holds any context bit or migrated-state bit, `lf_valid` and `rc_valid` are 0, and a snoop returns `snp_tp_out` = 0.
- R2: A local access with `acc_txn` = 1 that does not fault sets the bit of context `acc_ctx` on line `acc_line`. A non-transactional access (`acc_txn` = 0) sets no bit.
- R3: A local access to a line whose migrated-state bit is set faults with `lf_tp` = 1 and changes no bit.
- R4: A local access also faults when another context holds its bit on the line and either the access is a write (`acc_write` = 1) or the line is Modified (`acc_mod` = 1). A clean read by a second context is legal sharing and does not fault. `lf_holders` gives the other contexts' bits, with bit c standing for context c.
- R5: A read snoop (`snp_inv` = 0) of a line that has any context bit set and is Modified (`snp_mod` = 1) gives `rc_valid` with `rc_write` = 0. On a clean line the same snoop gives no conflict. In both cases the bits are kept.
- R6: An invalidating snoop (`snp_inv` = 1) of a line with any context bit set gives `rc_valid` with `rc_write` = 1. All context bits and the migrated-state bit of that line are clear from the next cycle on.
- R7: `snp_tp_out` is combinational in the snoop's own cycle. It is 1 exactly when `snp_valid` = 1 and the snooped line has any context bit or its migrated-state bit set.
- R8: `fill_valid` with `fill_tp` = 1 sets the line's migrated-state bit, and `tpclr_valid` clears it. When both target the same line in one cycle, the set wins.
- R9: A 1 on `txn_end[c]` clears context c's bit on every line by the next cycle.
- R10: `lf_valid` and `rc_valid` rise in the cycle after the offending input. Each pulse lasts one cycle per offending input, and its fields describe that input.
- R11: When an invalidating snoop and a local set, or a fill, hit the same line in one cycle, the invalidation wins. When `txn_end[c]` and a set by context c arrive in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Local access present |
| acc_line | input | LW | Line index of local access |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_ctx | input | CW | Hardware context of the access |
| acc_txn | input | 1 | Access is transactional |
| acc_mod | input | 1 | Line currently Modified in this cache |
| snp_valid | input | 1 | Incoming snoop present |
| snp_line | input | LW | Line index of the snoop |
| snp_inv | input | 1 | 1 = invalidate (remote write), 0 = read/downgrade |
| snp_mod | input | 1 | Snooped line is Modified here |
| snp_tp_out | output | 1 | Transfer indication returned with the snoop |
| fill_valid | input | 1 | Fill response present |
| fill_line | input | LW | Line index of the fill |
| fill_tp | input | 1 | Fill carries a transfer indication |
| tpclr_valid | input | 1 | Clear the migrated-state bit |
| tpclr_line | input | LW | Line to clear |
| txn_end | input | NCTX | Commit/abort pulse per context |
| lf_valid | output | 1 | Local access fault pulse |
| lf_line | output | LW | Faulting line |
| lf_ctx | output | CW | Faulting context |
| lf_write | output | 1 | Faulting access was a store |
| lf_tp | output | 1 | Migrated-state bit was set |
| lf_holders | output | NCTX | Other contexts holding the line |
| rc_valid | output | 1 | Remote conflict pulse |
| rc_line | output | LW | Conflicting line |
| rc_write | output | 1 | Remote access was a write |
| rc_holders | output | NCTX | Local contexts holding the line |

## Verification
Some properties are checked on every cycle. A migrated-state line always faults the next cycle. An invalidation always empties the line's bits. A commit empties its context's column. Every fault or conflict pulse traces back to an input in the previous cycle. The transfer indication never appears without a snoop. Other behaviour only the bench's scenarios can show: the exact contents of the holder masks, the difference between legal clean sharing and a Modified-line clash, the same-cycle priority cases, and the fact that non-transactional or faulting accesses leave no bits behind. The bench shows these through later accesses and snoops, and a random run compares every cycle against a requirement-level model.

// File: rtl/tmeta_pkg.sv
package tmeta_pkg;
  localparam int unsigned DEF_LINES = 16;
  localparam int unsigned DEF_CTX   = 2;

  typedef enum logic {
    SNP_READ = 1'b0,
    SNP_INV  = 1'b1
  } snp_kind_e;
endpackage

// File: rtl/tmeta_line.sv
module tmeta_line #(
  parameter int unsigned NCTX = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCTX-1:0] set_i,
  input  logic [NCTX-1:0] end_i,
  input  logic            inv_i,
  input  logic            tp_set_i,
  input  logic            tp_clr_i,
  output logic [NCTX-1:0] t_o,
  output logic            tp_o
);
  logic [NCTX-1:0] t_q, t_n;
  logic            tp_q, tp_n;
  logic            t_en, tp_en;

  always_comb begin
    t_n = (t_q & ~end_i) | set_i;
    if (inv_i) t_n = '0;
    tp_n = tp_q;
    if (tp_clr_i) tp_n = 1'b0;
    if (tp_set_i) tp_n = 1'b1;
    if (inv_i)    tp_n = 1'b0;
    t_en  = (|set_i) | (|end_i) | inv_i;
    tp_en = tp_set_i | tp_clr_i | inv_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q  <= '0;
      tp_q <= 1'b0;
    end else begin
      if (t_en)  t_q  <= t_n;
      if (tp_en) tp_q <= tp_n;
    end
  end

  assign t_o  = t_q;
  assign tp_o = tp_q;
endmodule

// File: rtl/tmeta_local_chk.sv
module tmeta_local_chk #(
  parameter int unsigned NCTX = 2,
  localparam int unsigned CW = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic            valid_i,
  input  logic            write_i,
  input  logic [CW-1:0]   ctx_i,
  input  logic            txn_i,
  input  logic            mod_i,
  input  logic [NCTX-1:0] t_line_i,
  input  logic            tp_line_i,
  output logic            fault_o,
  output logic [NCTX-1:0] holders_o,
  output logic [NCTX-1:0] set_o
);
  logic [NCTX-1:0] own;
  logic            clash;

  always_comb begin
    own       = NCTX'(1) << ctx_i;
    holders_o = t_line_i & ~own;
    clash     = (|holders_o) & (write_i | mod_i);
    fault_o   = valid_i & (tp_line_i | clash);
    set_o     = (valid_i & txn_i & ~fault_o) ? own : '0;
  end
endmodule

// File: rtl/tmeta_snoop_chk.sv
module tmeta_snoop_chk #(
  parameter int unsigned NCTX = 2
) (
  input  logic            valid_i,
  input  logic            inv_i,
  input  logic            mod_i,
  input  logic [NCTX-1:0] t_line_i,
  input  logic            tp_line_i,
  output logic            conf_o,
  output logic            tp_out_o
);
  import tmeta_pkg::*;
  snp_kind_e kind;
  logic      any_t;

  always_comb begin
    kind     = snp_kind_e'(inv_i);
    any_t    = |t_line_i;
    conf_o   = valid_i & any_t & ((kind == SNP_INV) | mod_i);
    tp_out_o = valid_i & (any_t | tp_line_i);
  end
endmodule

// File: rtl/tmeta_conflict_chk.sv
module tmeta_conflict_chk #(
  parameter int unsigned NLINES = tmeta_pkg::DEF_LINES,
  parameter int unsigned NCTX   = tmeta_pkg::DEF_CTX,
  localparam int unsigned LW = (NLINES > 1) ? $clog2(NLINES) : 1,
  localparam int unsigned CW = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic [LW-1:0]   acc_line,
  input  logic            acc_write,
  input  logic [CW-1:0]   acc_ctx,
  input  logic            acc_txn,
  input  logic            acc_mod,
  input  logic            snp_valid,
  input  logic [LW-1:0]   snp_line,
  input  logic            snp_inv,
  input  logic            snp_mod,
  output logic            snp_tp_out,
  input  logic            fill_valid,
  input  logic [LW-1:0]   fill_line,
  input  logic            fill_tp,
  input  logic            tpclr_valid,
  input  logic [LW-1:0]   tpclr_line,
  input  logic [NCTX-1:0] txn_end,
  output logic            lf_valid,
  output logic [LW-1:0]   lf_line,
  output logic [CW-1:0]   lf_ctx,
  output logic            lf_write,
  output logic            lf_tp,
  output logic [NCTX-1:0] lf_holders,
  output logic            rc_valid,
  output logic [LW-1:0]   rc_line,
  output logic            rc_write,
  output logic [NCTX-1:0] rc_holders
);
  logic [NLINES-1:0][NCTX-1:0] t_q;
  logic [NLINES-1:0]           tp_q;

  logic [NCTX-1:0] acc_t, snp_t;
  logic            acc_tp, snp_tp;
  logic            loc_fault, rem_conf;
  logic [NCTX-1:0] loc_holders, loc_set;

  assign acc_t  = t_q[acc_line];
  assign acc_tp = tp_q[acc_line];
  assign snp_t  = t_q[snp_line];
  assign snp_tp = tp_q[snp_line];

  tmeta_local_chk #(.NCTX(NCTX)) u_local (
    .valid_i   (acc_valid),
    .write_i   (acc_write),
    .ctx_i     (acc_ctx),
    .txn_i     (acc_txn),
    .mod_i     (acc_mod),
    .t_line_i  (acc_t),
    .tp_line_i (acc_tp),
    .fault_o   (loc_fault),
    .holders_o (loc_holders),
    .set_o     (loc_set)
  );

  tmeta_snoop_chk #(.NCTX(NCTX)) u_snoop (
    .valid_i   (snp_valid),
    .inv_i     (snp_inv),
    .mod_i     (snp_mod),
    .t_line_i  (snp_t),
    .tp_line_i (snp_tp),
    .conf_o    (rem_conf),
    .tp_out_o  (snp_tp_out)
  );

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    logic [NCTX-1:0] set_l;
    logic            inv_l, tps_l, tpc_l;
    assign set_l = (acc_line == LW'(l)) ? loc_set : '0;
    assign inv_l = snp_valid & snp_inv & (snp_line == LW'(l));
    assign tps_l = fill_valid & fill_tp & (fill_line == LW'(l));
    assign tpc_l = tpclr_valid & (tpclr_line == LW'(l));

    tmeta_line #(.NCTX(NCTX)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_l),
      .end_i    (txn_end),
      .inv_i    (inv_l),
      .tp_set_i (tps_l),
      .tp_clr_i (tpc_l),
      .t_o      (t_q[l]),
      .tp_o     (tp_q[l])
    );
  end

  // Output staging: next-state and register processes.
  logic            lf_valid_n, rc_valid_n;
  logic [LW-1:0]   lf_line_n, rc_line_n;
  logic [CW-1:0]   lf_ctx_n;
  logic            lf_write_n, lf_tp_n, rc_write_n;
  logic [NCTX-1:0] lf_holders_n, rc_holders_n;

  always_comb begin
    lf_valid_n   = loc_fault;
    lf_line_n    = acc_line;
    lf_ctx_n     = acc_ctx;
    lf_write_n   = acc_write;
    lf_tp_n      = acc_tp;
    lf_holders_n = loc_holders;
    rc_valid_n   = rem_conf;
    rc_line_n    = snp_line;
    rc_write_n   = snp_inv;
    rc_holders_n = snp_t;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf_valid   <= 1'b0;
      lf_line    <= '0;
      lf_ctx     <= '0;
      lf_write   <= 1'b0;
      lf_tp      <= 1'b0;
      lf_holders <= '0;
      rc_valid   <= 1'b0;
      rc_line    <= '0;
      rc_write   <= 1'b0;
      rc_holders <= '0;
    end else begin
      lf_valid <= lf_valid_n;
      rc_valid <= rc_valid_n;
      if (lf_valid_n) begin
        lf_line    <= lf_line_n;
        lf_ctx     <= lf_ctx_n;
        lf_write   <= lf_write_n;
        lf_tp      <= lf_tp_n;
        lf_holders <= lf_holders_n;
      end
      if (rc_valid_n) begin
        rc_line    <= rc_line_n;
        rc_write   <= rc_write_n;
        rc_holders <= rc_holders_n;
      end
    end
  end
endmodule

// File: rtl/tmeta_conflict_chk_sva.sv
module tmeta_conflict_chk_sva #(
  parameter int unsigned NLINES = 16,
  parameter int unsigned NCTX   = 2,
  localparam int unsigned LW = (NLINES > 1) ? $clog2(NLINES) : 1,
  localparam int unsigned CW = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        acc_valid,
  input logic [LW-1:0]               acc_line,
  input logic [CW-1:0]               acc_ctx,
  input logic                        acc_txn,
  input logic                        snp_valid,
  input logic [LW-1:0]               snp_line,
  input logic                        snp_inv,
  input logic                        snp_mod,
  input logic                        snp_tp_out,
  input logic [NCTX-1:0]             txn_end,
  input logic                        lf_valid,
  input logic                        lf_tp,
  input logic                        rc_valid,
  input logic                        rc_write,
  input logic [NLINES-1:0][NCTX-1:0] t_q,
  input logic [NLINES-1:0]           tp_q
);
  assert_tp_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && tp_q[acc_line] |=> lf_valid && lf_tp);

  assert_inv_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_inv |=> (t_q[$past(snp_line)] == '0) && !tp_q[$past(snp_line)]);

  assert_tpout_needs_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_tp_out |-> snp_valid);

  assert_tpout_on_migrated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && tp_q[snp_line] |-> snp_tp_out);

  assert_lf_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lf_valid |-> $past(acc_valid));

  assert_rc_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rc_valid |-> $past(snp_valid));

  assert_rc_read_modified_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rc_valid && !rc_write |-> $past(snp_mod) && !$past(snp_inv));

  for (genvar c = 0; c < NCTX; c++) begin : g_col
    logic col_any;
    always_comb begin
      col_any = 1'b0;
      for (int l = 0; l < NLINES; l++) col_any = col_any | t_q[l][c];
    end
    assert_end_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      txn_end[c] && !(acc_valid && acc_txn && acc_ctx == CW'(c)) |=> !col_any);
  end
endmodule

bind tmeta_conflict_chk tmeta_conflict_chk_sva #(.NLINES(NLINES), .NCTX(NCTX)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_line   (acc_line),
  .acc_ctx    (acc_ctx),
  .acc_txn    (acc_txn),
  .snp_valid  (snp_valid),
  .snp_line   (snp_line),
  .snp_inv    (snp_inv),
  .snp_mod    (snp_mod),
  .snp_tp_out (snp_tp_out),
  .txn_end    (txn_end),
  .lf_valid   (lf_valid),
  .lf_tp      (lf_tp),
  .rc_valid   (rc_valid),
  .rc_write   (rc_write),
  .t_q        (t_q),
  .tp_q       (tp_q)
);

// File: tb/tb_tmeta_conflict_chk.sv
`timescale 1ns/1ps
module tb_tmeta_conflict_chk;
  localparam int NL = 16;
  localparam int NC = 2;
  localparam int LW = 4;
  localparam int CW = 1;

  logic clk, rst_n;
  logic acc_valid, acc_write, acc_txn, acc_mod;
  logic [LW-1:0] acc_line;
  logic [CW-1:0] acc_ctx;
  logic snp_valid, snp_inv, snp_mod, snp_tp_out;
  logic [LW-1:0] snp_line;
  logic fill_valid, fill_tp, tpclr_valid;
  logic [LW-1:0] fill_line, tpclr_line;
  logic [NC-1:0] txn_end;
  logic lf_valid, lf_write, lf_tp, rc_valid, rc_write;
  logic [LW-1:0] lf_line, rc_line;
  logic [CW-1:0] lf_ctx;
  logic [NC-1:0] lf_holders, rc_holders;

  tmeta_conflict_chk #(.NLINES(NL), .NCTX(NC)) dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic lfv; logic [LW-1:0] lfl; logic [CW-1:0] lfc; logic lfw; logic lftp; logic [NC-1:0] lfh;
    logic rcv; logic [LW-1:0] rcl; logic rcw; logic [NC-1:0] rch;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [NC-1:0] mt [NL];
  logic          mtp[NL];

  task automatic chk(input bit ok, input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic step(input logic av, input logic [LW-1:0] al, input logic aw, input logic [CW-1:0] ac,
                      input logic at, input logic am, input logic sv, input logic [LW-1:0] sl,
                      input logic si, input logic sm, input logic fv, input logic [LW-1:0] fl,
                      input logic ft, input logic cv, input logic [LW-1:0] cl,
                      input logic [NC-1:0] en, input string tag);
    exp_t e;
    logic [NC-1:0] others;
    logic lf, rc, tpo;
    @(negedge clk);
    acc_valid = av; acc_line = al; acc_write = aw; acc_ctx = ac; acc_txn = at; acc_mod = am;
    snp_valid = sv; snp_line = sl; snp_inv = si; snp_mod = sm;
    fill_valid = fv; fill_line = fl; fill_tp = ft; tpclr_valid = cv; tpclr_line = cl; txn_end = en;
    others = mt[al] & ~(NC'(1) << ac);
    lf  = av && (mtp[al] || ((|others) && (aw || am)));
    rc  = sv && (|mt[sl]) && (si || sm);
    tpo = sv && ((|mt[sl]) || mtp[sl]);
    #1;
    chk(snp_tp_out == tpo, tag, "snp_tp_out", 32'(snp_tp_out), 32'(tpo));
    e = '0;
    e.lfv = lf; e.lfl = al; e.lfc = ac; e.lfw = aw; e.lftp = mtp[al]; e.lfh = others;
    e.rcv = rc; e.rcl = sl; e.rcw = si; e.rch = mt[sl];
    expq.push_back(e); tagq.push_back(tag);
    for (int l = 0; l < NL; l++) mt[l] = mt[l] & ~en;
    if (av && at && !lf) mt[al][ac] = 1'b1;
    if (cv) mtp[cl] = 1'b0;
    if (fv && ft) mtp[fl] = 1'b1;
    if (sv && si) begin mt[sl] = '0; mtp[sl] = 1'b0; end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, '0, tag);
  endtask
  task automatic acc(input logic [LW-1:0] l, input logic w, input logic [CW-1:0] c, input logic t, input logic m, input string tag);
    step(1, l, w, c, t, m, 0, 0, 0, 0, 0, 0, 0, 0, 0, '0, tag);
  endtask
  task automatic snp(input logic [LW-1:0] l, input logic inv, input logic m, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, l, inv, m, 0, 0, 0, 0, 0, '0, tag);
  endtask

  // Monitor: pops one expected item per cycle, after the edge that registers it.
  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) begin
      exp_t e; string tg;
      e = expq.pop_front(); tg = tagq.pop_front();
      chk(lf_valid == e.lfv, tg, "lf_valid", 32'(lf_valid), 32'(e.lfv));
      if (e.lfv && lf_valid)
        chk({lf_line, lf_ctx, lf_write, lf_tp, lf_holders} == {e.lfl, e.lfc, e.lfw, e.lftp, e.lfh},
            tg, "lf fields", 32'({lf_line, lf_ctx, lf_write, lf_tp, lf_holders}),
            32'({e.lfl, e.lfc, e.lfw, e.lftp, e.lfh}));
      chk(rc_valid == e.rcv, tg, "rc_valid", 32'(rc_valid), 32'(e.rcv));
      if (e.rcv && rc_valid)
        chk({rc_line, rc_write, rc_holders} == {e.rcl, e.rcw, e.rch}, tg, "rc fields",
            32'({rc_line, rc_write, rc_holders}), 32'({e.rcl, e.rcw, e.rch}));
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    for (int l = 0; l < NL; l++) begin mt[l] = '0; mtp[l] = 1'b0; end
    acc_valid = 0; acc_line = 0; acc_write = 0; acc_ctx = 0; acc_txn = 0; acc_mod = 0;
    snp_valid = 0; snp_line = 0; snp_inv = 0; snp_mod = 0;
    fill_valid = 0; fill_line = 0; fill_tp = 0; tpclr_valid = 0; tpclr_line = 0; txn_end = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!lf_valid && !rc_valid, "R1", "outputs in reset", 32'({lf_valid, rc_valid}), 0);
    rst_n = 1;
    idle("R1");
    snp(3, 1, 1, "R1");                  // empty line: no tp_out, no conflict
    // R2 / R4: transactional read then other-context write faults
    acc(5, 0, 0, 1, 0, "R2");
    acc(5, 1, 1, 0, 0, "R4");            // expect fault, holders = 01
    acc(7, 0, 1, 0, 0, "R2");            // non-transactional: no bit
    acc(7, 1, 0, 0, 0, "R2");            // no fault
    acc(5, 0, 1, 1, 0, "R4");            // clean sharing, no fault
    acc(5, 0, 1, 1, 1, "R4");            // modified read with other holder: fault
    // R5 read snoops
    snp(5, 0, 1, "R5");
    snp(5, 0, 0, "R5");
    // R9 commit clears columns
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b01, "R9");
    acc(5, 1, 0, 0, 0, "R9");            // ctx1 still holds: fault holders 10
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b10, "R9");
    acc(5, 1, 0, 0, 0, "R9");            // no fault
    snp(5, 0, 1, "R9");                  // no conflict, tp_out 0
    // R6 invalidations
    acc(9, 0, 0, 1, 0, "R6");
    snp(9, 1, 0, "R6");
    acc(9, 1, 1, 0, 0, "R6");
    snp(9, 1, 0, "R6");
    // R8 / R3 migrated-state bit
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 1, 0, 0, '0, "R8");
    snp(2, 0, 0, "R8");                  // tp_out from migrated bit only
    acc(2, 0, 0, 1, 0, "R3");            // fault with lf_tp
    acc(2, 1, 1, 1, 0, "R3");            // fault again
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 1, 1, 2, '0, "R8"); // set beats clear
    acc(2, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, '0, "R8");
    acc(2, 1, 1, 0, 0, "R3");            // no fault: faulting accesses left no bits
    // R11 priorities
    step(1, 4, 0, 0, 1, 0, 1, 4, 1, 0, 0, 0, 0, 0, 0, '0, "R11");
    acc(4, 1, 1, 0, 0, "R11");
    step(1, 6, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b01, "R11");
    acc(6, 1, 1, 0, 0, "R11");           // set beat clear: fault
    step(0, 0, 0, 0, 0, 0, 1, 8, 1, 0, 1, 8, 1, 0, 0, '0, "R11");
    acc(8, 0, 0, 0, 0, "R11");           // no fault
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b11, "R9");
    // R10 random stress against the requirement model
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], LW'($urandom_range(0, 7)), r[1], CW'(r[2]), r[3], r[4],
           r[5] & r[6], LW'($urandom_range(0, 7)), r[7] & r[8], r[9],
           (r[10:13] == 0), LW'($urandom_range(0, 7)), r[14],
           (r[15:17] == 0), LW'($urandom_range(0, 7)),
           (r[18:21] == 0) ? NC'(r[22:23]) : '0, "R10");
    end
    idle("R10");
    idle("R10");
    @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule